// File: doc/BRIEF.md
# Rotation Buffer Allocation Checker

This block decides whether every display layer that needs the shared rotation buffer can be served from two memory banks. Each layer presents three things: a flag saying it needs the buffer, because it is turned by 90 or 270 degrees or stored in a compressed format; a layer identifier; and the size it needs. The two bank sizes are plain inputs.

A one-cycle `start` pulse launches two passes over the layers, in index order, one layer per cycle. The first pass counts the layers that need the buffer. The second pass hands out usable space in order. The allocation favours the primary video layer. The last claimant takes whatever remains. The block then reports pass or fail and the usable amount granted to each layer.

Every input is a control or configuration value that is sampled during the walk, so there is no streaming interface. The caller must hold all layer and bank inputs steady while `busy` is high. Results stay valid until the next start.

Top module: `rot_buffer_checker`

## Requirements
- R1: A layer takes part in allocation only when its bit in `lyr_consume` is 1. For a layer whose bit is 0, the grant is 0 and the free amount does not change.
- R2: The free amount begins at `bank0_size`. `bank1_size` is added to it only when two or more layers have their consume bit set.
- R3: When the layer being allocated is the last remaining consumer, its usable amount is everything still free.
- R4: When more consumers remain, the layer's identifier equals `VIDEO_ID`, and `bank1_size` is non-zero, the usable amount is `bank0_size`, capped at the current free amount.
- R5: When more consumers remain in any other case, the usable amount is the current free amount shifted right by one, with the fraction dropped.
- R6: After each consumer, its usable amount is subtracted from free, and that usable amount is reported on its slice of `grant`. Layer k occupies bits [k*(SIZE_W+1) +: SIZE_W+1].
- R7: If a layer's required size exceeds its usable amount, `done` rises with `fail` set and no later layer is processed, so the grants of later layers stay 0.
- R8: `busy` is high from the cycle after `start` until the cycle in which `done` pulses for one cycle. `done` arrives 2*N_LAYERS cycles after the start edge on a pass. On a failure at layer j it arrives N_LAYERS+1+j cycles after the start edge.
- R9: A `start` pulse while `busy` is high is ignored. `fail` and `grant` hold their values until the next accepted start.
- R10: After reset, `busy`, `done` and `fail` are 0 and all grants are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that launches a check when idle |
| lyr_consume | input | N_LAYERS | Per-layer flag: layer needs the rotation buffer |
| lyr_id | input | N_LAYERS*ID_W | Per-layer identifier, layer k at [k*ID_W +: ID_W] |
| lyr_need | input | N_LAYERS*SIZE_W | Per-layer required size, layer k at [k*SIZE_W +: SIZE_W] |
| bank0_size | input | SIZE_W | Size of the first bank |
| bank1_size | input | SIZE_W | Size of the second bank (0 if absent) |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Last completed check failed |
| grant | output | N_LAYERS*(SIZE_W+1) | Usable amount granted to each layer |

## Verification
The bench builds the block with N_LAYERS=4, SIZE_W=10, ID_W=2 and VIDEO_ID=1. Four layers give all sixteen consumer patterns, so random stimulus reaches every position of the video layer among the claimants. That includes the case where the video layer comes after a half-share and hits the cap at the free amount. The narrow 10-bit sizes make odd free amounts and zero second banks frequent. Two full banks also exceed one bank's width, which exercises the extra grant bit.

// File: rtl/rot_buf_pkg.sv
package rot_buf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_ALLOC = 2'd2
  } rb_state_e;
endpackage

// File: rtl/rb_layer_pick.sv
module rb_layer_pick #(
  parameter int N_LAYERS = 4,
  parameter int ID_W     = 2,
  parameter int SIZE_W   = 10,
  localparam int IDX_W   = (N_LAYERS > 1) ? $clog2(N_LAYERS) : 1
) (
  input  logic [IDX_W-1:0]           idx,
  input  logic [N_LAYERS-1:0]        consume_all,
  input  logic [N_LAYERS*ID_W-1:0]   id_all,
  input  logic [N_LAYERS*SIZE_W-1:0] need_all,
  output logic                       sel_consume,
  output logic [ID_W-1:0]            sel_id,
  output logic [SIZE_W-1:0]          sel_need
);
  logic [ID_W-1:0]   id_arr   [N_LAYERS];
  logic [SIZE_W-1:0] need_arr [N_LAYERS];

  for (genvar k = 0; k < N_LAYERS; k++) begin : g_split
    assign id_arr[k]   = id_all[k*ID_W +: ID_W];
    assign need_arr[k] = need_all[k*SIZE_W +: SIZE_W];
  end

  always_comb begin
    sel_consume = consume_all[idx];
    sel_id      = id_arr[idx];
    sel_need    = need_arr[idx];
  end
endmodule

// File: rtl/rb_policy.sv
module rb_policy #(
  parameter int SIZE_W   = 10,
  parameter int ID_W     = 2,
  parameter int VIDEO_ID = 1,
  localparam int FREE_W  = SIZE_W + 1
) (
  input  logic              last_one,
  input  logic [ID_W-1:0]   id,
  input  logic [SIZE_W-1:0] bank0,
  input  logic [SIZE_W-1:0] bank1,
  input  logic [FREE_W-1:0] free_amt,
  output logic [FREE_W-1:0] usable
);
  logic              privileged;
  logic [FREE_W-1:0] bank0_ext;

  assign privileged = (id == ID_W'(VIDEO_ID)) && (bank1 != '0);
  assign bank0_ext  = {1'b0, bank0};

  always_comb begin
    if (last_one)
      usable = free_amt;
    else if (privileged)
      usable = (bank0_ext > free_amt) ? free_amt : bank0_ext;
    else
      usable = free_amt >> 1;
  end
endmodule

// File: rtl/rot_buffer_checker.sv
module rot_buffer_checker
  import rot_buf_pkg::*;
#(
  parameter int N_LAYERS = 4,
  parameter int ID_W     = 2,
  parameter int SIZE_W   = 10,
  parameter int VIDEO_ID = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [N_LAYERS-1:0]              lyr_consume,
  input  logic [N_LAYERS*ID_W-1:0]         lyr_id,
  input  logic [N_LAYERS*SIZE_W-1:0]       lyr_need,
  input  logic [SIZE_W-1:0]                bank0_size,
  input  logic [SIZE_W-1:0]                bank1_size,
  output logic                             busy,
  output logic                             done,
  output logic                             fail,
  output logic [N_LAYERS*(SIZE_W+1)-1:0]   grant
);
  localparam int IDX_W  = (N_LAYERS > 1) ? $clog2(N_LAYERS) : 1;
  localparam int CNT_W  = $clog2(N_LAYERS + 1);
  localparam int FREE_W = SIZE_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_LAYERS - 1);

  rb_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FREE_W-1:0] free_q;
  logic [FREE_W-1:0] gnt_q [N_LAYERS];

  logic              cur_consume;
  logic [ID_W-1:0]   cur_id;
  logic [SIZE_W-1:0] cur_need;
  logic [FREE_W-1:0] cur_usable;
  logic [CNT_W-1:0]  cnt_next;
  logic              over_need;

  rb_layer_pick #(.N_LAYERS(N_LAYERS), .ID_W(ID_W), .SIZE_W(SIZE_W)) u_pick (
    .idx         (idx_q),
    .consume_all (lyr_consume),
    .id_all      (lyr_id),
    .need_all    (lyr_need),
    .sel_consume (cur_consume),
    .sel_id      (cur_id),
    .sel_need    (cur_need)
  );

  rb_policy #(.SIZE_W(SIZE_W), .ID_W(ID_W), .VIDEO_ID(VIDEO_ID)) u_policy (
    .last_one (cnt_q == CNT_W'(1)),
    .id       (cur_id),
    .bank0    (bank0_size),
    .bank1    (bank1_size),
    .free_amt (free_q),
    .usable   (cur_usable)
  );

  assign cnt_next  = cnt_q + CNT_W'(cur_consume);
  assign over_need = {1'b0, cur_need} > cur_usable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      free_q  <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      fail    <= 1'b0;
      for (int k = 0; k < N_LAYERS; k++) gnt_q[k] <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_COUNT;
            idx_q   <= '0;
            cnt_q   <= '0;
            busy    <= 1'b1;
            fail    <= 1'b0;
            for (int k = 0; k < N_LAYERS; k++) gnt_q[k] <= '0;
          end
        end
        ST_COUNT: begin
          cnt_q <= cnt_next;
          if (idx_q == LAST_IDX) begin
            state_q <= ST_ALLOC;
            idx_q   <= '0;
            free_q  <= (cnt_next > CNT_W'(1)) ?
                       ({1'b0, bank0_size} + {1'b0, bank1_size}) :
                       {1'b0, bank0_size};
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_ALLOC: begin
          if (cur_consume) begin
            gnt_q[idx_q] <= cur_usable;
            free_q       <= free_q - cur_usable;
            cnt_q        <= cnt_q - 1'b1;
          end
          if (cur_consume && over_need) begin
            fail    <= 1'b1;
            done    <= 1'b1;
            busy    <= 1'b0;
            state_q <= ST_IDLE;
          end else if (idx_q == LAST_IDX) begin
            done    <= 1'b1;
            busy    <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < N_LAYERS; k++) begin : g_grant
    assign grant[k*FREE_W +: FREE_W] = gnt_q[k];
  end

  // R4: a grant handed out during allocation never exceeds what is free
  a_r4_usable_within_free: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ALLOC && cur_consume) |-> (cur_usable <= free_q));

  // R6: free only shrinks while allocating
  a_r6_free_nonincreasing: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ALLOC) |=> (free_q <= $past(free_q)));

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R9: fail only moves on an accepted start or at completion
  a_r9_fail_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!start || busy) |=> (done || $stable(fail)));
endmodule

// File: tb/rot_buffer_checker_test.sv
module rot_buffer_checker_test;
  localparam int N      = 4;
  localparam int ID_W   = 2;
  localparam int SW     = 10;
  localparam int VID    = 1;
  localparam int GW     = SW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] lyr_consume = '0;
  logic [N*ID_W-1:0] lyr_id = '0;
  logic [N*SW-1:0] lyr_need = '0;
  logic [SW-1:0] bank0_size = '0, bank1_size = '0;
  logic busy, done, fail;
  logic [N*GW-1:0] grant;

  int n_chk = 0, n_bad = 0;
  int c_cons [N];
  int c_id   [N];
  int c_need [N];
  int c_b0, c_b1;
  int e_g [N];
  int e_fail, e_lat;

  always #2 clk = ~clk;

  rot_buffer_checker #(.N_LAYERS(N), .ID_W(ID_W), .SIZE_W(SW), .VIDEO_ID(VID)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .lyr_consume(lyr_consume),
    .lyr_id(lyr_id), .lyr_need(lyr_need), .bank0_size(bank0_size),
    .bank1_size(bank1_size), .busy(busy), .done(done), .fail(fail), .grant(grant)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model();
    int total = 0, freev, rem, u;
    for (int k = 0; k < N; k++) begin total += c_cons[k]; e_g[k] = 0; end
    freev  = c_b0 + ((total > 1) ? c_b1 : 0);
    rem    = total;
    e_fail = 0;
    e_lat  = 2 * N;
    for (int k = 0; k < N; k++) begin
      if (c_cons[k] != 0) begin
        if (rem == 1) u = freev;
        else if (c_id[k] == VID && c_b1 != 0) u = (c_b0 > freev) ? freev : c_b0;
        else u = freev / 2;
        e_g[k] = u;
        freev -= u;
        rem--;
        if (c_need[k] > u) begin
          e_fail = 1;
          e_lat  = N + 1 + k;
          break;
        end
      end
    end
  endtask

  task automatic run_case(string tag, bit extra_start);
    int lat = 0;
    bit seen = 0;
    for (int k = 0; k < N; k++) begin
      lyr_consume[k] = c_cons[k][0];
      lyr_id[k*ID_W +: ID_W] = ID_W'(c_id[k]);
      lyr_need[k*SW +: SW] = SW'(c_need[k]);
    end
    bank0_size = SW'(c_b0);
    bank1_size = SW'(c_b1);
    model();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R8 busy after start"}, int'(busy), 1);
    for (int t = 0; t < 4 * N && !seen; t++) begin
      if (extra_start && t == 1) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (done) seen = 1;
    end
    chk({tag, " R8 latency"}, seen ? lat : -1, e_lat);
    chk({tag, " R7 fail flag"}, int'(fail), e_fail);
    for (int k = 0; k < N; k++)
      chk({tag, " R6 grant"}, int'(grant[k*GW +: GW]), e_g[k]);
    @(negedge clk);
    chk({tag, " R9 held"}, int'(fail), e_fail);
    chk({tag, " R8 idle"}, int'(busy), 0);
  endtask

  task automatic setl(int k, int cons, int id, int need);
    c_cons[k] = cons; c_id[k] = id; c_need[k] = need;
  endtask

  initial begin
    int dummy;
    dummy = $urandom(1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 fail", int'(fail), 0);
    chk("R10 grant", int'(grant), 0);

    // R1: no consumers -> pass, zero grants
    for (int k = 0; k < N; k++) setl(k, 0, k, 900);
    c_b0 = 100; c_b1 = 100;
    run_case("R1 none", 0);

    // R2 / R3: single consumer gets bank0 only
    setl(2, 1, 0, 200);
    c_b0 = 200; c_b1 = 300;
    run_case("R2 single", 0);

    // R4: video first, bank1 present -> takes bank0, last gets bank1
    for (int k = 0; k < N; k++) setl(k, 0, 0, 0);
    setl(0, 1, VID, 250); setl(3, 1, 2, 300);
    c_b0 = 250; c_b1 = 300;
    run_case("R4 video first", 0);

    // R5: bank1 zero -> video layer gets half, odd truncation
    c_b0 = 201; c_b1 = 0; c_need[0] = 100; c_need[3] = 101;
    run_case("R5 no bank1", 0);

    // R4 cap: video after a half-share with three consumers
    for (int k = 0; k < N; k++) setl(k, 0, 0, 0);
    setl(0, 1, 2, 10); setl(1, 1, VID, 10); setl(2, 1, 3, 0);
    c_b0 = 800; c_b1 = 100;
    run_case("R4 cap", 0);

    // R7: early failure stops later layers
    for (int k = 0; k < N; k++) setl(k, 1, 2, 1000);
    c_b0 = 50; c_b1 = 50;
    run_case("R7 fail first", 0);

    // R9: start during busy ignored
    for (int k = 0; k < N; k++) setl(k, k & 1, k, 20);
    c_b0 = 512; c_b1 = 512;
    run_case("R9 restart ignored", 1);

    // R5 random mix
    for (int r = 0; r < 300; r++) begin
      c_b0 = $urandom % 1024;
      c_b1 = (($urandom % 4) == 0) ? 0 : $urandom % 1024;
      for (int k = 0; k < N; k++)
        setl(k, $urandom % 2, $urandom % 4, $urandom % (c_b0 / 2 + 64));
      run_case("R5 random", 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R8: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule